// File: doc/BRIEF.md
# Two-Wire Control Register Port with Pointer Auto-Advance

This block is a two-wire serial (I2C) target that lets a host reach a bank of 8-bit control registers held outside the block. It oversamples the clock and data lines with the system clock. It detects start and stop conditions, shifts bytes in and out, and pulls the data line low to acknowledge. A register-file interface carries the register address, the write data, a one-cycle write strobe and the read data.

A write transaction has three parts. First comes the device address with the direction bit low. Next comes a pointer byte: its top bit is an advance flag and its low seven bits select a register. Any number of data bytes follow. To read, the host first writes the pointer byte. It then issues a repeated start with the direction bit high and clocks bytes out until it declines to acknowledge. One register returns a fixed identification byte and ignores writes.

Top module: `i2c_regport`

## Requirements
- R1: The target answers the 7-bit device address formed by the fixed upper bits 100101 followed by the `addr_strap` pin. The address arrives as the first byte after a start, MSB first, with bit 0 as the direction (1 = read, 0 = write). The target acknowledges by pulling SDA low during the ninth clock.
- R2: When the device address does not match, the target does not acknowledge, keeps SDA released for the rest of the transaction and produces no write strobe.
- R3: In a write, the byte after the device address is the pointer byte. Bit 7 is the advance flag and bits 6:0 load the register pointer. The target acknowledges this byte.
- R4: With the advance flag at 0, every data byte written goes to the same register, and every byte read comes from the same register.
- R5: With the advance flag at 1, the pointer increases by one after each byte written or read.
- R6: Register 01h always reads as D9h: identification 11011 in bits 7:3 and revision 001 in bits 2:0. The external read data is not used for this register.
- R7: A write to register 01h is acknowledged, but no write strobe is issued for it.
- R8: Each data byte written, received MSB first, produces exactly one `reg_we` pulse lasting one cycle. During that pulse `reg_addr` holds the current pointer and `reg_wdata` holds the byte. Every data byte is acknowledged.
- R9: Advancing from register 7Fh wraps the pointer to 00h.
- R10: A read after a repeated start begins at the pointer that was last loaded. The target drives data MSB first and changes SDA only while SCL is low. A byte the host does not acknowledge ends the read, and SDA is then released.
- R11: A stop returns the target to idle. A start at any point, including partway through a byte, begins a new address phase and discards the partial byte. The pointer is kept.
- R12: While reset is active and right after it, SDA is released and `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 1 | Lowest bit of the device address |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |
| reg_addr | output | 7 | Current register pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
The bench covers four corner cases, each tied to a specific wrong behaviour:
- Pointer wrap from 7Fh: an off-by-one or a pointer that saturates would write to 80h or stay at 7Fh, so register 00h would keep its old contents.
- Identification register: a wrong design would strobe on writes to 01h, or read back the external file instead of D9h.
- Mismatched address: if an address mismatch still acknowledged, or still wrote, a stray zero would appear on the ack bit or the strobe count would change.
- Start partway through a byte: if the partial bits were kept, the bits before the new start would spill into the next transaction and land in the wrong register.

The bench also flips the advance flag between transactions. A pointer that advanced regardless of the flag would spread a non-advancing write across neighbouring registers.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int BYTE_W     = 8;
  localparam int DEV_ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_MAP, ST_MACK,
    ST_WR, ST_WACK, ST_RD, ST_RACK
  } rp_state_e;

  // Device address compare: upper fixed bits plus strap, direction bit excluded.
  function automatic logic addr_match(logic [BYTE_W-1:0] rx,
                                      logic [DEV_ADDR_W-2:0] fixed_bits,
                                      logic strap);
    return rx[BYTE_W-1:1] == {fixed_bits, strap};
  endfunction

  // Identification byte: chip code in the upper bits, revision in the lower.
  function automatic logic [BYTE_W-1:0] id_value(logic [4:0] chip, logic [2:0] rev);
    return {chip, rev};
  endfunction
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign cur[g]  = chain[STAGES-1];
    assign prev[g] = last;
  end
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             load_inc,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             step
);
  logic inc_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  assign step = adv & inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      inc_q <= 1'b0;
    end else if (load) begin
      ptr   <= load_val;
      inc_q <= load_inc;
    end else if (step) begin
      ptr <= bump(ptr);
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_rp_pkg::*;
#(
  parameter int                    PTR_W       = 7,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [DEV_ADDR_W-2:0] FIXED_ADDR  = 6'b100101,
  parameter logic [4:0]            CHIP_CODE   = 5'b11011,
  parameter logic [2:0]            REV_CODE    = 3'b001,
  parameter logic [PTR_W-1:0]      ID_REG      = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_pull,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam int                CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST_TX  = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ID_VAL   = id_value(CHIP_CODE, REV_CODE);

  logic [1:0] line_cur, line_prev;
  logic scl_s, sda_s, scl_p, sda_p;
  i2c_rp_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}),
    .cur(line_cur), .prev(line_prev)
  );
  assign {scl_s, sda_s} = line_cur;
  assign {scl_p, sda_p} = line_prev;

  // Named bus events
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_evt = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

  rp_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rw_q, nack_q;

  wire byte_in_done = scl_fall && (bit_cnt == FULL_CNT);
  wire map_load     = (state == ST_MAP) && byte_in_done;
  wire wr_fire      = (state == ST_WR) && byte_in_done;
  wire rd_fire      = (state == ST_RD) && scl_fall && (bit_cnt == LAST_TX);
  wire ptr_adv      = wr_fire | rd_fire;
  wire in_idle      = (state == ST_IDLE);
  wire ptr_step;

  logic [PTR_W-1:0] ptr;
  i2c_rp_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(map_load),
    .load_val(rx_sh[PTR_W-1:0]), .load_inc(rx_sh[BYTE_W-1]),
    .adv(ptr_adv), .ptr(ptr), .step(ptr_step)
  );

  wire [BYTE_W-1:0] rd_byte = (ptr == ID_REG) ? ID_VAL : reg_rdata;

  assign reg_addr  = ptr;
  assign reg_wdata = rx_sh;
  assign reg_we    = wr_fire && (ptr != ID_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_MAP, ST_WR: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_in_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_match(rx_sh, FIXED_ADDR, addr_strap)) begin
                rw_q     <= rx_sh[0];
                state    <= ST_AACK;
                sda_pull <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state    <= (state == ST_MAP) ? ST_MACK : ST_WACK;
              sda_pull <= 1'b1;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          bit_cnt <= '0;
          if (rw_q) begin
            tx_sh    <= rd_byte;
            sda_pull <= ~rd_byte[BYTE_W-1];
            state    <= ST_RD;
          end else begin
            sda_pull <= 1'b0;
            state    <= ST_MAP;
          end
        end
        ST_MACK, ST_WACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          bit_cnt  <= '0;
          state    <= ST_WR;
        end
        ST_RD: if (scl_fall) begin
          if (bit_cnt == LAST_TX) begin
            sda_pull <= 1'b0;
            state    <= ST_RACK;
          end else begin
            tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
            sda_pull <= ~tx_sh[BYTE_W-2];
            bit_cnt  <= bit_cnt + 1'b1;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state <= ST_IDLE;
            end else begin
              tx_sh    <= rd_byte;
              sda_pull <= ~rd_byte[BYTE_W-1];
              bit_cnt  <= '0;
              state    <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int             PTR_W  = 7,
  parameter logic [PTR_W-1:0] ID_REG = 7'h01
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_pull,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr,
  input logic             in_idle,
  input logic             ptr_step
);
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_ro_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr != ID_REG));

  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && $past(in_idle)) |-> $stable(reg_addr));
endmodule

bind i2c_regport i2c_regport_chk #(.PTR_W(PTR_W), .ID_REG(ID_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull),
  .reg_we(reg_we), .reg_addr(reg_addr), .in_idle(in_idle), .ptr_step(ptr_step)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_pull, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] rf [128];
  wire sda_bus = sda_m & ~sda_pull;
  int n_chk = 0, n_fail = 0, we_cnt = 0, id_we = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_regport dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap(strap), .reg_rdata(reg_rdata), .sda_pull(sda_pull),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we)
  );

  // Register file model outside the block
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) rf[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
      if (reg_addr == 7'h01) id_we <= id_we + 1;
    end
  end
  assign reg_rdata = rf[reg_addr];

  typedef struct packed { logic [7:0] map; logic [7:0] data; logic [7:0] expv; } vec_t;
  localparam vec_t VEC [6] = '{
    '{8'h05, 8'h3C, 8'h3C}, '{8'h01, 8'hAA, 8'hD9}, '{8'h7F, 8'h81, 8'h81},
    '{8'h00, 8'hFF, 8'hFF}, '{8'h42, 8'h00, 8'h00}, '{8'h2A, 8'h96, 8'h96}};

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2); b = sda_bus; wt(H / 2);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(nack);
  endtask

  function automatic logic [7:0] waddr();
    return {6'b100101, strap, 1'b0};
  endfunction

  task automatic begin_write(input logic [7:0] map);
    logic a;
    bus_start();
    wbyte(waddr(), a); chk("R1 addr ack", {7'd0, a}, 8'h00);
    wbyte(map, a);     chk("R3 map ack", {7'd0, a}, 8'h00);
  endtask

  task automatic begin_read(input logic [7:0] map);
    logic a;
    begin_write(map);
    bus_start();
    wbyte(waddr() | 8'h01, a); chk("R10 read addr ack", {7'd0, a}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] d;
    int w0;
    wt(5);
    chk("R12 pull in reset", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    wt(5);
    chk("R12 pull after reset", {7'd0, sda_pull}, 8'h00);
    chk("R12 strobe after reset", {7'd0, reg_we}, 8'h00);

    // Vector table: write one byte, then read it back (R8, R6)
    for (int i = 0; i < 6; i++) begin
      begin_write(VEC[i].map);
      wbyte(VEC[i].data, a); chk("R8 data ack", {7'd0, a}, 8'h00);
      bus_stop();
      begin_read(VEC[i].map);
      rbyte(1'b1, d); bus_stop();
      chk((VEC[i].map == 8'h01) ? "R6 id readback" : "R8 readback", d, VEC[i].expv);
    end
    chk("R7 no strobe on 01h", 8'(id_we), 8'h00);

    // Advancing write then read (R5, R10)
    w0 = we_cnt;
    begin_write(8'h90);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a);
    bus_stop();
    chk("R8 three strobes", 8'(we_cnt - w0), 8'h03);
    chk("R5 reg 10h", rf[16], 8'h11);
    chk("R5 reg 11h", rf[17], 8'h22);
    chk("R5 reg 12h", rf[18], 8'h33);
    begin_read(8'h90);
    rbyte(1'b0, d); chk("R5 read 10h", d, 8'h11);
    rbyte(1'b0, d); chk("R5 read 11h", d, 8'h22);
    rbyte(1'b1, d); chk("R5 read 12h", d, 8'h33);
    wt(4);
    chk("R10 released after nack", {7'd0, sda_pull}, 8'h00);
    bus_stop();
    begin_read(8'h80);
    rbyte(1'b0, d); chk("R5 read 00h", d, rf[0]);
    rbyte(1'b0, d); chk("R6 id in burst", d, 8'hD9);
    rbyte(1'b1, d); chk("R5 read 02h", d, rf[2]);
    bus_stop();

    // Non-advancing write and read (R4)
    begin_write(8'h20);
    wbyte(8'hA1, a); wbyte(8'hB2, a);
    bus_stop();
    chk("R4 same reg", rf[32], 8'hB2);
    chk("R4 neighbour", rf[33], 8'h7B);
    begin_read(8'h20);
    rbyte(1'b0, d); chk("R4 read first", d, 8'hB2);
    rbyte(1'b1, d); chk("R4 read second", d, 8'hB2);
    bus_stop();

    // Wrap from 7Fh (R9)
    begin_write(8'hFF);
    wbyte(8'hC3, a); wbyte(8'hD4, a);
    bus_stop();
    chk("R9 reg 7Fh", rf[127], 8'hC3);
    chk("R9 wrapped 00h", rf[0], 8'hD4);

    // Write to identification register is acked (R7)
    begin_write(8'h01);
    wbyte(8'h00, a); chk("R7 ack on 01h", {7'd0, a}, 8'h00);
    bus_stop();
    chk("R7 no strobe", 8'(id_we), 8'h00);

    // Mismatched address (R2)
    w0 = we_cnt;
    bus_start();
    wbyte(8'h96, a); chk("R2 no ack", {7'd0, a}, 8'h01);
    wbyte(8'h05, a); chk("R2 stays released", {7'd0, a}, 8'h01);
    wbyte(8'hEE, a); chk("R2 stays released 2", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R2 no strobe", 8'(we_cnt - w0), 8'h00);

    // Strap selects the low address bit (R1)
    strap = 1'b1;
    begin_write(8'h12);
    wbyte(8'h77, a);
    bus_stop();
    chk("R1 strap write", rf[18], 8'h77);
    strap = 1'b0;

    // Start partway through a byte (R11)
    begin_write(8'h30);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    begin_write(8'h31);
    wbyte(8'h5E, a);
    bus_stop();
    chk("R11 aborted byte", rf[48], 8'h30 ^ 8'h5A);
    chk("R11 new write", rf[49], 8'h5E);
    // Pointer kept across stop (R11)
    bus_start();
    wbyte(waddr() | 8'h01, a);
    rbyte(1'b1, d); bus_stop();
    chk("R11 pointer kept", d, 8'h5E);

    summary();
  end
endmodule